// File: doc/BRIEF.md
# JTAG Host Bit Shift Engine

This block is the host side of a JTAG link. It produces TCK, TMS and TDI and samples TDO. Each command either moves a single field of 1 to 32 bits through whatever register the target TAP has in its shift path, or walks the TAP between its standard states. Every field transfer has its own settings:

- the bit count;
- whether the word goes out from the low or the high end;
- whether TMS rises on the last bit so that the TAP leaves the shift state;
- whether the engine then steps the TAP on to Run-Test/Idle.

Because of these settings, several transfers can be joined into one long scan that never leaves Shift-DR.

A controller places a command on the inputs and pulses `start`. The engine raises `busy` and drives the TCK cycles the command needs. When the last TCK phase ends it drops `busy` and pulses `done`. At that point `rdata` holds the bits taken from TDO, at the same bit positions as the TDI bits they were shifted against. TCK runs at a selectable fraction of the system clock. Each TCK phase lasts at least one system clock.

Top module: `jtag_shift_master`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `tck` and `rdata` are all 0, `tms` is 1, and `tdi` is 0.
- R2: A field transfer (`cmd` = 2'b00) produces exactly N TCK cycles, plus the exit cycles of R6. `len_code` values 1..31 give N = len_code, and 0 gives N = 32.
- R3: With `msb_first` = 0, TCK cycle i carries `wdata[i]` on TDI. With `msb_first` = 1, cycle i carries `wdata[N-1-i]`.
- R4: The TDO value present just before the falling TCK edge that closes cycle i is written to the same bit position of `rdata` that cycle i took its TDI bit from. All other `rdata` bits read 0 after a field transfer.
- R5: With `end_shift` = 1, TMS is high during the last bit of the field and low during all earlier bits. With `end_shift` = 0, TMS stays low for every bit.
- R6: After an ending field, `ret_idle` = 1 adds two TCK cycles carrying TMS 1 then 0, and `ret_idle` = 0 adds one cycle carrying TMS 1. TDI is 0 in these cycles. `ret_idle` has no effect when `end_shift` = 0.
- R7: TMS and TDI change only while TCK is low, and they hold steady for the whole high phase.
- R8: The TAP reset command (`cmd` = 2'b01) drives five TCK cycles with TMS high, then one cycle with TMS low.
- R9: The Shift-IR command (`cmd` = 2'b10) drives TMS 1,1,0,0 over four cycles. The Shift-DR command (`cmd` = 2'b11) drives TMS 1,0,0 over three cycles. Both keep TDI at 0 and leave `rdata` unchanged.
- R10: Each TCK phase lasts `tck_half` system clocks, with 0 treated as 1. The value is taken when the command is accepted and is held until the command ends.
- R11: A `start` pulse while `busy` is 1 is ignored. The running command's pins, timing and captured word are unchanged.
- R12: `done` is a one-cycle pulse. It rises at the same clock edge that produces the final falling TCK edge, and `busy` falls at that edge. For a command of C TCK cycles with phase length L, this is 2·L·C clocks after the edge that accepted `start`. TCK is low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, taken only when idle |
| cmd | input | 2 | 00 field transfer, 01 TAP reset, 10 go to Shift-IR, 11 go to Shift-DR |
| len_code | input | 5 | Field length, 0 meaning 32 |
| msb_first | input | 1 | Shift from the high end of the field |
| end_shift | input | 1 | Raise TMS on the last bit |
| ret_idle | input | 1 | Continue to Run-Test/Idle after an ending field |
| wdata | input | 32 | Word to shift out |
| tck_half | input | 8 | System clocks per TCK phase |
| tdo | input | 1 | Serial data from the target |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Word captured from TDO |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data to the target |

## Verification
Each command has a known TCK cycle count C: N plus 0, 1 or 2 for a field, 6 for reset, 4 for Shift-IR and 3 for Shift-DR. So `done` and the final `rdata` are due exactly 2·L·C clocks after the accepting edge. The bench waits that exact number of clocks and checks that `done` is still low one clock earlier, high at the due clock, and low again one clock later. The TMS and TDI values of each cycle are due at that cycle's rising TCK edge. The bench samples them there, while TCK is high, and compares them in order with an expected queue built from the requirements. An empty queue at the due clock shows that no cycle was dropped. A cycle with no queue entry shows an extra one. Every high phase is also timed against L.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

  typedef enum logic [1:0] {
    JCMD_FIELD = 2'b00,
    JCMD_RESET = 2'b01,
    JCMD_TO_IR = 2'b10,
    JCMD_TO_DR = 2'b11
  } jcmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BITS,
    ST_WALK
  } seq_state_e;

endpackage

// File: rtl/jsm_phase_timer.sv
// Marks the last system clock of each TCK phase.
module jsm_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] half_in,
  input  logic             run,
  output logic             tick
);

  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) begin
        lim_q <= (half_in == '0) ? '0 : half_in - 1'b1;
      end
      if (!run) begin
        cnt_q <= '0;
      end else if (cnt_q == lim_q) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick = run && (cnt_q == lim_q);

endmodule

// File: rtl/jsm_field_path.sv
// Holds the outgoing word, walks the bit index in either direction and
// collects TDO bits at the index of the bit they were shifted against.
module jsm_field_path #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  len_code,
  input  logic              msb_first,
  input  logic              tdo,
  output logic              first_bit,
  output logic              first_last,
  output logic              next_bit,
  output logic              cur_last,
  output logic              next_last,
  output logic [DATA_W-1:0] rx
);

  localparam int CNT_W = IDX_W + 1;

  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  left_q;
  logic              msb_q;

  logic [CNT_W-1:0]  n_bits;
  logic [IDX_W-1:0]  top_idx;
  logic [IDX_W-1:0]  first_idx;
  logic [IDX_W-1:0]  nxt_idx;

  assign n_bits     = (len_code == '0) ? CNT_W'(DATA_W) : {1'b0, len_code};
  assign top_idx    = IDX_W'(n_bits - CNT_W'(1));
  assign first_idx  = msb_first ? top_idx : '0;
  assign first_bit  = wdata[first_idx];
  assign first_last = (n_bits == CNT_W'(1));

  assign nxt_idx    = msb_q ? (idx_q - IDX_W'(1)) : (idx_q + IDX_W'(1));
  assign next_bit   = data_q[nxt_idx];
  assign cur_last   = (left_q == '0);
  assign next_last  = (left_q == IDX_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
      msb_q  <= 1'b0;
    end else if (load) begin
      data_q <= wdata;
      idx_q  <= first_idx;
      left_q <= top_idx;
      msb_q  <= msb_first;
    end else if (step && !cur_last) begin
      idx_q  <= nxt_idx;
      left_q <= left_q - IDX_W'(1);
    end
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_cap
    logic cap_q;
    always_ff @(posedge clk) begin
      if (rst || load) begin
        cap_q <= 1'b0;
      end else if (step && (idx_q == IDX_W'(g))) begin
        cap_q <= tdo;
      end
    end
    assign rx[g] = cap_q;
  end

endmodule

// File: rtl/jsm_sequencer.sv
// Command FSM: field bits, then fixed TMS walks for navigation and exit.
module jsm_sequencer #(
  parameter int RST_HOLD = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  jsm_pkg::jcmd_e     cmd,
  input  logic               end_shift,
  input  logic               ret_idle,
  input  logic               tick,
  input  logic               first_bit,
  input  logic               first_last,
  input  logic               next_bit,
  input  logic               cur_last,
  input  logic               next_last,
  output logic               fld_load,
  output logic               fld_step,
  output logic               tmr_load,
  output logic               busy,
  output logic               done,
  output logic               tck,
  output logic               tms,
  output logic               tdi
);
  import jsm_pkg::*;

  localparam int WALK_W = RST_HOLD + 1;
  localparam int LEN_W  = $clog2(WALK_W + 1);

  localparam logic [WALK_W-1:0] PAT_RST  = WALK_W'((1 << RST_HOLD) - 1);
  localparam logic [LEN_W-1:0]  LEN_RST  = LEN_W'(WALK_W);
  localparam logic [WALK_W-1:0] PAT_IR   = WALK_W'(3);
  localparam logic [LEN_W-1:0]  LEN_IR   = LEN_W'(4);
  localparam logic [WALK_W-1:0] PAT_DR   = WALK_W'(1);
  localparam logic [LEN_W-1:0]  LEN_DR   = LEN_W'(3);
  localparam logic [WALK_W-1:0] PAT_EXIT = WALK_W'(1);
  localparam logic [LEN_W-1:0]  LEN_IDLE = LEN_W'(2);
  localparam logic [LEN_W-1:0]  LEN_UPD  = LEN_W'(1);

  seq_state_e        state_q;
  logic              tck_q, tms_q, tdi_q, done_q;
  logic              end_q, ret_q;
  logic [WALK_W-1:0] walk_q;
  logic [LEN_W-1:0]  wlen_q;

  logic [WALK_W-1:0] nav_pat;
  logic [LEN_W-1:0]  nav_len;
  logic              accept, rise, fall;

  assign accept   = start && (state_q == ST_IDLE);
  assign rise     = tick && !tck_q;
  assign fall     = tick && tck_q;
  assign fld_load = accept && (cmd == JCMD_FIELD);
  assign fld_step = (state_q == ST_BITS) && fall;
  assign tmr_load = accept;

  always_comb begin
    case (cmd)
      JCMD_RESET: begin nav_pat = PAT_RST; nav_len = LEN_RST; end
      JCMD_TO_IR: begin nav_pat = PAT_IR;  nav_len = LEN_IR;  end
      default:    begin nav_pat = PAT_DR;  nav_len = LEN_DR;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tck_q   <= 1'b0;
      tms_q   <= 1'b1;
      tdi_q   <= 1'b0;
      done_q  <= 1'b0;
      end_q   <= 1'b0;
      ret_q   <= 1'b0;
      walk_q  <= '0;
      wlen_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            end_q <= end_shift;
            ret_q <= ret_idle;
            tck_q <= 1'b0;
            if (cmd == JCMD_FIELD) begin
              tms_q   <= end_shift && first_last;
              tdi_q   <= first_bit;
              state_q <= ST_BITS;
            end else begin
              walk_q  <= nav_pat;
              wlen_q  <= nav_len;
              tms_q   <= nav_pat[0];
              tdi_q   <= 1'b0;
              state_q <= ST_WALK;
            end
          end
        end
        ST_BITS: begin
          if (rise) begin
            tck_q <= 1'b1;
          end else if (fall) begin
            tck_q <= 1'b0;
            if (!cur_last) begin
              tms_q <= end_q && next_last;
              tdi_q <= next_bit;
            end else if (end_q) begin
              walk_q  <= PAT_EXIT;
              wlen_q  <= ret_q ? LEN_IDLE : LEN_UPD;
              tms_q   <= PAT_EXIT[0];
              tdi_q   <= 1'b0;
              state_q <= ST_WALK;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WALK: begin
          if (rise) begin
            tck_q <= 1'b1;
          end else if (fall) begin
            tck_q <= 1'b0;
            if (wlen_q == LEN_W'(1)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              walk_q <= walk_q >> 1;
              wlen_q <= wlen_q - LEN_W'(1);
              tms_q  <= walk_q[1];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign tck  = tck_q;
  assign tms  = tms_q;
  assign tdi  = tdi_q;

endmodule

// File: rtl/jtag_shift_master.sv
module jtag_shift_master #(
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 8,
  parameter int RST_HOLD = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [1:0]                cmd,
  input  logic [$clog2(DATA_W)-1:0] len_code,
  input  logic                      msb_first,
  input  logic                      end_shift,
  input  logic                      ret_idle,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [DIV_W-1:0]          tck_half,
  input  logic                      tdo,
  output logic                      busy,
  output logic                      done,
  output logic [DATA_W-1:0]         rdata,
  output logic                      tck,
  output logic                      tms,
  output logic                      tdi
);
  import jsm_pkg::*;

  logic fld_load, fld_step, tmr_load, tick;
  logic first_bit, first_last, next_bit, cur_last, next_last;

  jsm_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .half_in (tck_half),
    .run     (busy),
    .tick    (tick)
  );

  jsm_field_path #(.DATA_W(DATA_W)) u_field (
    .clk        (clk),
    .rst        (rst),
    .load       (fld_load),
    .step       (fld_step),
    .wdata      (wdata),
    .len_code   (len_code),
    .msb_first  (msb_first),
    .tdo        (tdo),
    .first_bit  (first_bit),
    .first_last (first_last),
    .next_bit   (next_bit),
    .cur_last   (cur_last),
    .next_last  (next_last),
    .rx         (rdata)
  );

  jsm_sequencer #(.RST_HOLD(RST_HOLD)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cmd        (jcmd_e'(cmd)),
    .end_shift  (end_shift),
    .ret_idle   (ret_idle),
    .tick       (tick),
    .first_bit  (first_bit),
    .first_last (first_last),
    .next_bit   (next_bit),
    .cur_last   (cur_last),
    .next_last  (next_last),
    .fld_load   (fld_load),
    .fld_step   (fld_step),
    .tmr_load   (tmr_load),
    .busy       (busy),
    .done       (done),
    .tck        (tck),
    .tms        (tms),
    .tdi        (tdi)
  );

endmodule

// File: rtl/jsm_checker.sv
module jsm_checker (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic tck,
  input logic tms,
  input logic tdi
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R12

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R12

  AST_TCK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tck); // R12

  AST_PINS_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    tck |-> ($stable(tms) && $stable(tdi))); // R7

  AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> ($stable(tms) && $stable(tdi) && $stable(tck))); // R11

endmodule

bind jtag_shift_master jsm_checker u_chk (
  .clk  (clk),
  .rst  (rst),
  .busy (busy),
  .done (done),
  .tck  (tck),
  .tms  (tms),
  .tdi  (tdi)
);

// File: tb/jtag_shift_master_tb_top.sv
`timescale 1ns/100ps
module jtag_shift_master_tb_top;

  typedef struct packed { logic tms; logic tdi; } pin_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [1:0]  cmd;
  logic [4:0]  len_code;
  logic        msb_first, end_shift, ret_idle;
  logic [31:0] wdata;
  logic [7:0]  tck_half;
  logic        tdo;
  logic        busy, done, tck, tms, tdi;
  logic [31:0] rdata;

  int          n_tests = 0;
  int          n_fail  = 0;
  pin_t        exp_q[$];
  string       cur_tag = "R1";
  int          exp_L   = 1;
  logic [63:0] tdo_pat = '0;
  int          fall_cnt = 0;

  always #2.5 clk = ~clk;

  assign tdo = tdo_pat[fall_cnt[5:0]];

  jtag_shift_master dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .len_code(len_code),
    .msb_first(msb_first), .end_shift(end_shift), .ret_idle(ret_idle),
    .wdata(wdata), .tck_half(tck_half), .tdo(tdo), .busy(busy), .done(done),
    .rdata(rdata), .tck(tck), .tms(tms), .tdi(tdi)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic ms, input logic di);
    pin_t p;
    p.tms = ms;
    p.tdi = di;
    exp_q.push_back(p);
  endtask

  // Monitor: pops one expected pin pair per rising TCK, times high phases.
  initial begin
    logic prev;
    int   hi;
    logic ltms, ltdi;
    pin_t e;
    prev = 1'b0;
    hi   = 0;
    ltms = 1'b0;
    ltdi = 1'b0;
    forever begin
      @(negedge clk);
      if (rst) begin
        prev = 1'b0;
      end else begin
        if (tck && !prev) begin
          hi = 1; ltms = tms; ltdi = tdi;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2", 64'd1, 64'd0, "unexpected TCK cycle");
          end else begin
            e = exp_q.pop_front();
            chk(tms == e.tms, cur_tag, 64'(tms), 64'(e.tms), "TMS");
            chk(tdi == e.tdi, cur_tag, 64'(tdi), 64'(e.tdi), "TDI");
          end
        end else if (tck) begin
          hi++;
          chk(tms == ltms && tdi == ltdi, "R7", {62'd0, tms, tdi}, {62'd0, ltms, ltdi},
              "pins moved while TCK high");
        end else if (prev) begin
          chk(hi == exp_L, "R10", 64'(hi), 64'(exp_L), "TCK high phase length");
          fall_cnt++;
        end
        prev = tck;
      end
    end
  end

  // Driver: builds the expected queue, runs the command, checks done timing.
  task automatic run_cmd(input logic [1:0] c, input logic [4:0] nsel, input bit msb,
                         input bit en, input bit ri, input logic [31:0] wd, input int half,
                         input logic [63:0] tp, input bit inject, input string tag);
    int n, L, cyc, idx;
    logic [31:0] exp_rd;
    L   = (half == 0) ? 1 : half;
    n   = (nsel == 5'd0) ? 32 : int'(nsel);
    exp_rd = rdata;
    cyc = 0;
    case (c)
      2'b00: begin
        exp_rd = '0;
        for (int i = 0; i < n; i++) begin
          idx = msb ? (n - 1 - i) : i;
          exp_rd[idx] = tp[i];
          push(en && (i == n - 1), wd[idx]);
        end
        cyc = n;
        if (en) begin
          push(1'b1, 1'b0); cyc++;
          if (ri) begin push(1'b0, 1'b0); cyc++; end
        end
      end
      2'b01: begin
        for (int i = 0; i < 5; i++) push(1'b1, 1'b0);
        push(1'b0, 1'b0); cyc = 6;
      end
      2'b10: begin
        push(1'b1, 1'b0); push(1'b1, 1'b0); push(1'b0, 1'b0); push(1'b0, 1'b0); cyc = 4;
      end
      default: begin
        push(1'b1, 1'b0); push(1'b0, 1'b0); push(1'b0, 1'b0); cyc = 3;
      end
    endcase
    @(negedge clk);
    cur_tag = tag; exp_L = L; tdo_pat = tp; fall_cnt = 0;
    cmd = c; len_code = nsel; msb_first = msb; end_shift = en; ret_idle = ri;
    wdata = wd; tck_half = 8'(half); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R12", 64'(busy), 64'd1, "busy after accept");
    for (int k = 1; k < 2 * L * cyc; k++) begin
      if (inject && k == 3) begin
        start = 1'b1; cmd = 2'b01; tck_half = 8'd7; wdata = ~wd;   // R11 stray start
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b0 && busy == 1'b1, "R12", {62'd0, done, busy}, 64'd1, "done/busy one clock early");
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0 && tck == 1'b0, "R12", {61'd0, done, busy, tck}, 64'd4,
        "done/busy/tck at due clock");
    chk(rdata == exp_rd, tag, 64'(rdata), 64'(exp_rd), "captured word");
    chk(exp_q.size() == 0, "R2", 64'(exp_q.size()), 64'd0, "TCK cycles missing");
    @(negedge clk);
    chk(done == 1'b0, "R12", 64'(done), 64'd0, "done width");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog expired: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; cmd = 2'b00; len_code = 5'd0; msb_first = 1'b0;
    end_shift = 1'b0; ret_idle = 1'b0; wdata = '0; tck_half = 8'd1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && done == 0 && tck == 0 && tms == 1 && tdi == 0, "R1",
        {59'd0, busy, done, tck, tms, tdi}, 64'h2, "pins in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && tck == 0 && tms == 1, "R1",
        {60'd0, busy, done, tck, tms}, 64'h1, "pins after reset");
    chk(rdata == '0, "R1", 64'(rdata), 64'd0, "rdata after reset");

    run_cmd(2'b01, 5'd0, 0, 0, 0, 32'h0, 1, 64'h0, 0, "R8 R12");
    run_cmd(2'b11, 5'd0, 0, 0, 0, 32'h0, 2, 64'h0, 0, "R9");
    run_cmd(2'b00, 5'd4, 0, 1, 1, 32'h0000000A, 1, 64'h5, 0, "R2 R3 R4 R5 R6");
    run_cmd(2'b00, 5'd0 + 5'd0, 1, 0, 0, 32'hC0DE1234, 2, 64'h9E3779B9, 0, "R3 R4 R5");
    run_cmd(2'b00, 5'd9, 1, 0, 1, 32'h000001A5, 1, 64'h1C3, 0, "R2 R3 R4 R6");
    run_cmd(2'b00, 5'd5, 0, 1, 0, 32'h00000013, 1, 64'h0B, 0, "R5 R6");
    run_cmd(2'b10, 5'd0, 0, 0, 0, 32'hFFFFFFFF, 1, 64'h0, 0, "R9");
    run_cmd(2'b00, 5'd1, 0, 1, 1, 32'h00000001, 1, 64'h1, 0, "R2 R6");
    run_cmd(2'b00, 5'd0, 0, 1, 1, 32'h80000001, 3, 64'h3FFFF0000, 0, "R2 R4 R10");
    run_cmd(2'b00, 5'd9, 0, 1, 0, 32'h00000155, 2, 64'h0AA, 1, "R11 R10");
    run_cmd(2'b00, 5'd5, 1, 1, 1, 32'h00000016, 0, 64'h19, 0, "R10 R3");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule